// File: doc/BRIEF.md
# NAND Flash Byte-Cycle Sequencer

This block sits between a simple single-master memory-mapped bus and a raw NAND flash device. Every bus access to the flash window moves one byte across the flash's 8-bit bus. Three address bits of that access decide what the flash sees: a command-latch cycle, an address-latch cycle, or a plain data cycle. Issuing a command byte and then the row and column bytes, one access each, is enough to drive any flash operation from software or a small engine.

Each byte cycle passes through an optional one-cycle setup phase, a strobe (wait) phase, a hold phase and a recovery phase. Their lengths come from one of four timing registers, and the control register picks which one. The control register also enables flash mode, picks the chip-enable pin, asserts write protect and sets the active level of each pin group. A status register reports the flash ready/busy pin and a completion flag that software checks after every byte.

Top module: `nand_cycle_seq`

## Requirements
- R1: After reset all outputs are low, flash mode is off, the control register reads 0, every timing register reads 0x0000_0294 (recovery 1, hold 1, read wait 2, write wait 2, setup off) and status bit 3 reads 0.
- R2: An access with address bit 7 clear is a flash byte. Address bit 3 drives the command latch, bit 2 drives the address latch and bit 4 drives the selected chip enable. These are asserted during the setup, wait and hold phases only.
- R3: A flash byte in flash mode runs 1 setup cycle if timing bit 22 is set. It then runs a wait of N cycles (N is the wait field, and 0 counts as 1), then hold-field cycles, then recovery-field cycles. bus_ready is then high for exactly one cycle.
- R4: On a flash write the write strobe is asserted only during the wait phase. The data bus drives bus_wdata[7:0] with output enable high during the wait and hold phases, and is 0 with enable low otherwise.
- R5: On a flash read the read strobe is asserted during the wait phase. The byte on nand_dq_i at the edge that ends the last wait cycle is returned in bus_rdata[7:0] while bus_ready is high, with the upper bits 0.
- R6: Control bits 9:8 select which timing register (0 to 3) a flash byte uses. Control bits 11:10 select which nand_ce pin is driven. At most one chip enable is active at a time.
- R7: Control bit 4 inverts the chip enables, bit 5 inverts the write and read strobes, bit 6 inverts write protect and bit 7 inverts both latch pins. Control bit 1 asserts write protect.
- R8: Status bit 0 is nand_rb (1 = ready) seen through a two-flop synchronizer. Status bit 3 is set by the completion of every flash byte. Register accesses leave bit 3 unchanged.
- R9: With control bit 0 clear, a flash byte completes with bus_ready in the first cycle after acceptance, moves no pin, and reads as 0.
- R10: Registers are at 0x80 (control, writable bits 0, 1 and 11:4), 0x84 (status, writes ignored) and 0xC0 + 4*i (timing i, writable bits 22 and 9:2). A register access returns bus_ready in the first cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access request, held until bus_ready |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address (flash window or register) |
| bus_wdata | input | 32 | Write data (flash uses bits 7:0) |
| bus_ready | output | 1 | One-cycle completion pulse |
| bus_rdata | output | 32 | Read data, valid while bus_ready is high |
| nand_ce | output | CS_N | Chip enables |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we | output | 1 | Write strobe |
| nand_re | output | 1 | Read strobe |
| nand_wp | output | 1 | Write protect |
| nand_dq_o | output | 8 | Flash data out |
| nand_dq_oe | output | 1 | Flash data output enable |
| nand_dq_i | input | 8 | Flash data in |
| nand_rb | input | 1 | Flash ready/busy, 1 = ready |

## Verification
Register accesses and flash bytes with flash mode off are due one cycle after the accepting edge. A flash byte in flash mode is due after setup + wait + hold + recovery cycles, and every pin follows a phase known for each of those cycles. The bench expands each access into a queue of per-cycle phases from its own copy of the register values and compares every output at the falling edge of each cycle. A read byte is checked against the value the bench put on the data input during the final wait cycle. A ready/busy change is read back only after at least three edges, to cover the two synchronizer flops.

// File: rtl/nand_cycle_seq.sv
module nand_cycle_seq #(
  parameter int CS_N = 4,
  parameter logic [31:0] TIM_RST = 32'h0000_0294
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_valid,
  input  logic            bus_write,
  input  logic [7:0]      bus_addr,
  input  logic [31:0]     bus_wdata,
  output logic            bus_ready,
  output logic [31:0]     bus_rdata,
  output logic [CS_N-1:0] nand_ce,
  output logic            nand_cle,
  output logic            nand_ale,
  output logic            nand_we,
  output logic            nand_re,
  output logic            nand_wp,
  output logic [7:0]      nand_dq_o,
  output logic            nand_dq_oe,
  input  logic [7:0]      nand_dq_i,
  input  logic            nand_rb
);
  localparam logic [31:0] TIM_MASK = 32'h0040_03FC;
  localparam logic [31:0] CTL_MASK = 32'h0000_0FF3;

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_WAIT, S_HOLD, S_RECOV, S_DONE} st_t;

  st_t         st;
  logic [1:0]  cnt;
  logic [31:0] ctl;
  logic [31:0] tim [CS_N];
  logic [31:0] rdata_q, tim_rd;
  logic [3:0]  a_q;
  logic        wr_q, done_flag, rb_s1, rb_s2;
  logic [7:0]  wd_q;
  logic [1:0]  hld_q, rec_q;
  logic        sel_setup;
  logic [1:0]  sel_rec, sel_hld, sel_rdw, sel_wrw, w_acc;
  logic [CS_N-1:0] ce_l;
  logic        unused_bits;

  assign unused_bits = ^{bus_addr[1:0], bus_addr[5]};

  always_comb begin
    sel_setup = 1'b0; sel_rec = '0; sel_hld = '0; sel_rdw = '0; sel_wrw = '0;
    tim_rd = '0;
    for (int i = 0; i < CS_N; i++) begin
      if (ctl[9:8] == 2'(i)) begin
        sel_setup = tim[i][22];
        sel_rec   = tim[i][3:2];
        sel_hld   = tim[i][5:4];
        sel_rdw   = tim[i][7:6];
        sel_wrw   = tim[i][9:8];
      end
      if (bus_addr[3:2] == 2'(i)) tim_rd = tim[i];
    end
  end

  assign w_acc = bus_write ? sel_wrw : sel_rdw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; ctl <= '0; rdata_q <= '0; a_q <= '0;
      wr_q <= 1'b0; wd_q <= '0; hld_q <= '0; rec_q <= '0;
      done_flag <= 1'b0; rb_s1 <= 1'b0; rb_s2 <= 1'b0;
      for (int i = 0; i < CS_N; i++) tim[i] <= TIM_RST & TIM_MASK;
    end else begin
      rb_s1 <= nand_rb;
      rb_s2 <= rb_s1;
      case (st)
        S_IDLE: if (bus_valid) begin
          a_q     <= {bus_addr[7], bus_addr[4:2]};
          wr_q    <= bus_write;
          wd_q    <= bus_wdata[7:0];
          hld_q   <= sel_hld;
          rec_q   <= sel_rec;
          rdata_q <= '0;
          if (bus_addr[7]) begin
            st <= S_DONE;
            if (bus_write) begin
              if (!bus_addr[6]) begin
                if (!bus_addr[2]) ctl <= bus_wdata & CTL_MASK;
              end else begin
                for (int i = 0; i < CS_N; i++)
                  if (bus_addr[3:2] == 2'(i)) tim[i] <= bus_wdata & TIM_MASK;
              end
            end else begin
              rdata_q <= bus_addr[6] ? tim_rd :
                         bus_addr[2] ? {28'd0, done_flag, 2'b00, rb_s2} : ctl;
            end
          end else begin
            done_flag <= 1'b0;
            if (!ctl[0]) st <= S_DONE;
            else begin
              st  <= sel_setup ? S_SETUP : S_WAIT;
              cnt <= (w_acc == 2'd0) ? 2'd0 : w_acc - 2'd1;
            end
          end
        end
        S_SETUP: st <= S_WAIT;
        S_WAIT: if (cnt == 2'd0) begin
          if (!wr_q) rdata_q <= {24'd0, nand_dq_i};
          if (hld_q != 2'd0) begin
            st <= S_HOLD; cnt <= hld_q - 2'd1;
          end else if (rec_q != 2'd0) begin
            st <= S_RECOV; cnt <= rec_q - 2'd1;
          end else st <= S_DONE;
        end else cnt <= cnt - 2'd1;
        S_HOLD: if (cnt == 2'd0) begin
          if (rec_q != 2'd0) begin
            st <= S_RECOV; cnt <= rec_q - 2'd1;
          end else st <= S_DONE;
        end else cnt <= cnt - 2'd1;
        S_RECOV: if (cnt == 2'd0) st <= S_DONE;
                 else cnt <= cnt - 2'd1;
        S_DONE: begin
          st <= S_IDLE;
          if (!a_q[3]) done_flag <= 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  wire act   = (st == S_SETUP) || (st == S_WAIT) || (st == S_HOLD);
  wire ce_a  = act && a_q[2];
  wire we_a  = (st == S_WAIT) && wr_q;
  wire re_a  = (st == S_WAIT) && !wr_q;

  for (genvar g = 0; g < CS_N; g++) begin : g_ce
    assign ce_l[g]    = ce_a && (ctl[11:10] == 2'(g));
    assign nand_ce[g] = ce_l[g] ^ ctl[4];
  end

  assign nand_cle   = (act && a_q[1]) ^ ctl[7];
  assign nand_ale   = (act && a_q[0]) ^ ctl[7];
  assign nand_we    = we_a ^ ctl[5];
  assign nand_re    = re_a ^ ctl[5];
  assign nand_wp    = ctl[1] ^ ctl[6];
  assign nand_dq_oe = wr_q && ((st == S_WAIT) || (st == S_HOLD));
  assign nand_dq_o  = nand_dq_oe ? wd_q : 8'd0;
  assign bus_ready  = (st == S_DONE);
  assign bus_rdata  = bus_ready ? rdata_q : 32'd0;

  assert_ready_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ready |=> !bus_ready);

  assert_ce_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ce_l));

  assert_flag_after_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_flag) |-> $past(bus_ready));

  assert_mode_off_fast_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && bus_valid && !bus_addr[7] && !ctl[0]) |=> bus_ready);

  assert_reg_fast_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && bus_valid && bus_addr[7]) |=> bus_ready);

  assert_no_strobe_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_ready) |-> !(we_a || re_a || nand_dq_oe));
endmodule

// File: tb/sim_nand_cycle_seq.sv
module sim_nand_cycle_seq;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_ready;
  logic [31:0] bus_rdata;
  logic [3:0]  nand_ce;
  logic        nand_cle, nand_ale, nand_we, nand_re, nand_wp, nand_dq_oe;
  logic [7:0]  nand_dq_o;
  logic [7:0]  nand_dq_i = '0;
  logic        nand_rb = 1'b1;

  nand_cycle_seq u0 (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
    .bus_rdata(bus_rdata), .nand_ce(nand_ce), .nand_cle(nand_cle),
    .nand_ale(nand_ale), .nand_we(nand_we), .nand_re(nand_re), .nand_wp(nand_wp),
    .nand_dq_o(nand_dq_o), .nand_dq_oe(nand_dq_oe), .nand_dq_i(nand_dq_i),
    .nand_rb(nand_rb)
  );

  int checks = 0, errors = 0;
  logic [31:0] m_ctl = '0;
  logic [31:0] m_tim [4];
  bit m_flag = 1'b0;

  wire [18:0] act_pins = {nand_ce, nand_cle, nand_ale, nand_we, nand_re, nand_wp,
                          nand_dq_oe, nand_dq_o, bus_ready};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // phase codes: 0 idle, 1 setup, 2 wait, 3 hold, 4 recovery, 5 done
  function automatic logic [18:0] expect_pins(input int ph, input logic [7:0] a,
                                              input bit wr, input logic [7:0] wd);
    logic [3:0] ce;
    logic act, oe;
    act = (ph >= 1 && ph <= 3);
    for (int i = 0; i < 4; i++) ce[i] = ((m_ctl[11:10] == 2'(i)) && act && a[4]) ^ m_ctl[4];
    oe = wr && (ph == 2 || ph == 3);
    return {ce, (act && a[3]) ^ m_ctl[7], (act && a[2]) ^ m_ctl[7],
            ((ph == 2) && wr) ^ m_ctl[5], ((ph == 2) && !wr) ^ m_ctl[5],
            m_ctl[1] ^ m_ctl[6], oe, oe ? wd : 8'h00, ph == 5};
  endfunction

  task automatic access(input bit wr, input logic [7:0] a, input logic [31:0] wd,
                        input string tag);
    int ph[$];
    int w;
    logic [31:0] t, exp_rd;
    @(negedge clk);
    chk(tag, 32'(act_pins), 32'(expect_pins(0, a, wr, wd[7:0])));
    t = m_tim[m_ctl[9:8]];
    exp_rd = '0;
    if (a[7] || !m_ctl[0]) ph.push_back(5);
    else begin
      if (t[22]) ph.push_back(1);
      w = wr ? int'(t[9:8]) : int'(t[7:6]);
      if (w == 0) w = 1;
      repeat (w) ph.push_back(2);
      repeat (int'(t[5:4])) ph.push_back(3);
      repeat (int'(t[3:2])) ph.push_back(4);
      ph.push_back(5);
    end
    if (a[7] && !wr)
      exp_rd = a[6] ? m_tim[a[3:2]] : (a[2] ? {28'd0, m_flag, 2'b00, nand_rb} : m_ctl);
    if (a[7] && wr && !a[6] && !a[2]) m_ctl = wd & 32'h0000_0FF3;
    if (a[7] && wr && a[6]) m_tim[a[3:2]] = wd & 32'h0040_03FC;
    bus_valid = 1'b1; bus_write = wr; bus_addr = a; bus_wdata = wd;
    foreach (ph[k]) begin
      @(negedge clk);
      if (ph[k] == 2) begin
        nand_dq_i = 8'hA0 + 8'(k);
        if (!wr) exp_rd = {24'd0, nand_dq_i};
      end
      chk(tag, 32'(act_pins), 32'(expect_pins(ph[k], a, wr, wd[7:0])));
      if (ph[k] == 5) chk(tag, bus_rdata, exp_rd);
    end
    bus_valid = 1'b0;
    if (!a[7]) m_flag = 1'b1;
  endtask

  task automatic idle(input int n, input string tag);
    repeat (n) begin
      @(negedge clk);
      chk(tag, 32'(act_pins), 32'(expect_pins(0, 8'h00, 1'b0, 8'h00)));
    end
  endtask

  initial begin
    for (int i = 0; i < 4; i++) m_tim[i] = 32'h0000_0294;
    idle(3, "R1");
    rst_n = 1'b1;
    idle(2, "R1");
    access(0, 8'h80, 0, "R1");
    access(0, 8'hC0, 0, "R1");
    access(0, 8'hCC, 0, "R1");
    access(0, 8'h84, 0, "R1");
    access(1, 8'h80, 32'hFFFF_F073, "R10");
    access(0, 8'h80, 0, "R10");
    access(1, 8'h84, 32'hFFFF_FFFF, "R10");
    access(0, 8'h84, 0, "R10");
    access(1, 8'hC4, 32'hFFFF_FFFF, "R10");
    access(0, 8'hC4, 0, "R10");
    access(1, 8'h80, 32'h0000_0073, "R10");
    access(1, 8'h18, 32'h0000_0070, "R2");
    access(1, 8'h14, 32'h0000_0001, "R2");
    access(1, 8'h14, 32'h0000_0022, "R2");
    access(1, 8'h14, 32'h0000_0043, "R2");
    access(1, 8'h08, 32'h0000_0030, "R2");
    access(1, 8'h10, 32'h0000_005A, "R4");
    access(1, 8'h10, 32'h0000_00C3, "R4");
    access(0, 8'h10, 0, "R5");
    access(0, 8'h10, 0, "R5");
    access(0, 8'h84, 0, "R8");
    nand_rb = 1'b0;
    idle(3, "R8");
    access(0, 8'h84, 0, "R8");
    nand_rb = 1'b1;
    idle(3, "R8");
    access(0, 8'h84, 0, "R8");
    access(1, 8'h80, 32'h0000_0173, "R6");
    access(1, 8'h10, 32'h0000_0011, "R3");
    access(0, 8'h10, 0, "R3");
    access(1, 8'hC8, 32'h0040_0000, "R3");
    access(1, 8'h80, 32'h0000_0A73, "R6");
    access(1, 8'h18, 32'h0000_0090, "R3");
    access(0, 8'h14, 0, "R3");
    access(1, 8'hCC, 32'h0000_0144, "R3");
    access(1, 8'h80, 32'h0000_0F73, "R6");
    access(1, 8'h18, 32'h0000_0000, "R6");
    access(0, 8'h10, 0, "R6");
    access(1, 8'h80, 32'h0000_0001, "R7");
    access(1, 8'h1C, 32'h0000_003C, "R7");
    access(1, 8'h80, 32'h0000_00F1, "R7");
    access(0, 8'h14, 0, "R7");
    access(1, 8'h80, 32'h0000_0043, "R7");
    access(1, 8'h10, 32'h0000_0081, "R7");
    access(1, 8'h80, 32'h0000_0000, "R9");
    access(1, 8'h18, 32'h0000_00FF, "R9");
    access(0, 8'h10, 0, "R9");
    access(0, 8'h84, 0, "R8");
    idle(2, "R9");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R3 actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule